// File: doc/BRIEF.md
# DMA Channel Address Generator

This block forms the bus addresses for one DMA channel that runs in short-address mode. It holds two software-visible address registers. The memory-side register is a 24-bit pointer that steps after every transfer. The peripheral-side register is an 8-bit offset into the top 256 bytes of the 24-bit address space. For each transfer the block presents a source address and a destination address. Which register feeds which output depends only on the event that activated the channel.

Software reads and writes both registers one byte at a time through a small register port. The transfer engine pulses a done strobe once per completed transfer. It also supplies the transfer size and the step mode, and the memory pointer then moves by one or two, or stays where it is. Neither register has a reset value. Software must load both before the channel is started.

Top module: `dma_addr_gen`

## Requirements
- R1: Register port index 0 is the reserved top byte of the memory pointer. A read there returns 0xFF, and a write there changes neither that value nor any other register.
- R2: Register port indices 1, 2 and 3 read and write memory pointer bits 23:16, 15:8 and 7:0. Read data appears on `cpu_rdata` one clock after the index is presented.
- R3: When `act_src` is 1 (serial receive-full) or 2 (A/D conversion end), `dst_addr` carries the memory pointer and `src_addr` carries the peripheral address.
- R4: When `act_src` is 0 or 3 (any other trigger), `src_addr` carries the memory pointer and `dst_addr` carries the peripheral address.
- R5: The peripheral address is 0xFFFF in bits 23:8 with the 8-bit peripheral register in bits 7:0. That register is read and written at register port index 4.
- R6: With `step_mode` 1, each `xfer_done` pulse adds 1 to the memory pointer when `xfer_size` is 0 (byte) and adds 2 when it is 1 (word).
- R7: With `step_mode` 2, each `xfer_done` pulse subtracts 1 (byte) or 2 (word) from the memory pointer.
- R8: With `step_mode` 0 or 3, an `xfer_done` pulse leaves the memory pointer unchanged.
- R9: Pointer arithmetic wraps modulo 2^24. Stepping past 0xFFFFFF or below 0x000000 never changes the reserved byte, which still reads 0xFF.
- R10: A CPU write to any memory pointer byte in the same cycle as `xfer_done` takes effect, and that cycle's step is dropped.
- R11: Reset does not alter the memory pointer or the peripheral register.
- R12: `src_addr`, `dst_addr` and `cpu_rdata` are registered. They are 0 while `rst` is high, and otherwise they reflect register contents and `act_src` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset for the output registers |
| cpu_addr | input | 3 | Register port byte index |
| cpu_we | input | 1 | Register port write enable |
| cpu_wdata | input | 8 | Register port write data |
| cpu_rdata | output | 8 | Register port read data, one cycle latency |
| act_src | input | 2 | Activation source: 0/3 other, 1 serial receive, 2 A/D end |
| xfer_size | input | 1 | 0 byte, 1 word |
| step_mode | input | 2 | 0/3 fixed, 1 increment, 2 decrement |
| xfer_done | input | 1 | One-cycle strobe per completed transfer |
| src_addr | output | 24 | Registered source bus address |
| dst_addr | output | 24 | Registered destination bus address |

## Verification
The bench builds the block with its default parameters: a 24-bit pointer split into 8-bit lanes and an 8-bit peripheral register. With those values, a word step can carry across lane boundaries and wrap at 2^24 within a few transfers, so both pointer edges are reached directly. The tests drive every activation code and step mode. One test collides a CPU write with a done strobe, and another pulses reset between loads and read-backs.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;

  typedef enum logic [1:0] {
    ACT_OTHER_A = 2'd0,
    ACT_SER_RX  = 2'd1,
    ACT_ADC_END = 2'd2,
    ACT_OTHER_B = 2'd3
  } act_src_e;

  typedef enum logic [1:0] {
    STEP_HOLD_A = 2'd0,
    STEP_UP     = 2'd1,
    STEP_DOWN   = 2'd2,
    STEP_HOLD_B = 2'd3
  } step_mode_e;

  // Memory side is destination for these triggers
  function automatic logic mem_is_dest(input logic [1:0] act);
    return (act == ACT_SER_RX) || (act == ACT_ADC_END);
  endfunction

endpackage

// File: rtl/dma_mem_ptr.sv
module dma_mem_ptr #(
  parameter int ADDR_W = 24,
  parameter int BYTE_W = 8,
  localparam int NLANES = ADDR_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLANES-1:0] wr_lane,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              step_en,
  input  logic              step_word,
  input  logic [1:0]        step_mode,
  output logic [ADDR_W-1:0] ptr_q
);
  import dma_ag_pkg::*;

  logic [ADDR_W-1:0] delta;
  logic [ADDR_W-1:0] stepped;
  logic              any_wr;

  assign any_wr = |wr_lane;
  assign delta  = step_word ? ADDR_W'(2) : ADDR_W'(1);

  // Arithmetic is ADDR_W wide, so carries and borrows wrap here
  always_comb begin
    stepped = ptr_q;
    if (step_en) begin
      case (step_mode)
        STEP_UP:   stepped = ptr_q + delta;
        STEP_DOWN: stepped = ptr_q - delta;
        default:   stepped = ptr_q;
      endcase
    end
  end

  // No reset: contents are left to software
  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (any_wr) begin
        if (wr_lane[i]) ptr_q[i*BYTE_W +: BYTE_W] <= wr_data;
      end else begin
        ptr_q[i*BYTE_W +: BYTE_W] <= stepped[i*BYTE_W +: BYTE_W];
      end
    end
  end

  a_r6_step_up: assert property (@(posedge clk) disable iff (rst)
    (step_en && !any_wr && step_mode == STEP_UP) |=> ptr_q == $past(ptr_q) + $past(delta));

  a_r7_step_down: assert property (@(posedge clk) disable iff (rst)
    (step_en && !any_wr && step_mode == STEP_DOWN) |=> ptr_q == $past(ptr_q) - $past(delta));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!any_wr && (step_mode == STEP_HOLD_A || step_mode == STEP_HOLD_B)) |=> $stable(ptr_q));

  a_r10_write_wins: assert property (@(posedge clk) disable iff (rst)
    (wr_lane[0] && step_en) |=> ptr_q[BYTE_W-1:0] == $past(wr_data));

endmodule

// File: rtl/dma_io_reg.sv
module dma_io_reg #(
  parameter int IO_W = 8
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [IO_W-1:0] wr_data,
  output logic [IO_W-1:0] io_q
);
  // No reset: contents are left to software
  always_ff @(posedge clk) begin
    if (wr_en) io_q <= wr_data;
  end
endmodule

// File: rtl/dma_addr_route.sv
module dma_addr_route #(
  parameter int ADDR_W = 24
) (
  input  logic [1:0]        act_src,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [ADDR_W-1:0] io_addr,
  output logic [ADDR_W-1:0] src_nxt,
  output logic [ADDR_W-1:0] dst_nxt
);
  import dma_ag_pkg::*;

  always_comb begin
    if (mem_is_dest(act_src)) begin
      src_nxt = io_addr;
      dst_nxt = mem_addr;
    end else begin
      src_nxt = mem_addr;
      dst_nxt = io_addr;
    end
  end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int ADDR_W  = 24,
  parameter int BYTE_W  = 8,
  parameter int IO_W    = 8,
  parameter int CPU_AW  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic [BYTE_W-1:0] cpu_wdata,
  output logic [BYTE_W-1:0] cpu_rdata,
  input  logic [1:0]        act_src,
  input  logic              xfer_size,
  input  logic [1:0]        step_mode,
  input  logic              xfer_done,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr
);
  import dma_ag_pkg::*;

  localparam int NLANES  = ADDR_W / BYTE_W;
  localparam int IDX_RSV = 0;
  localparam int IDX_IO  = NLANES + 1;
  localparam int HI_W    = ADDR_W - IO_W;

  logic [NLANES-1:0] lane_wr;
  logic              io_wr;
  logic [ADDR_W-1:0] ptr_q;
  logic [IO_W-1:0]   io_q;
  logic [ADDR_W-1:0] io_full;
  logic [ADDR_W-1:0] src_nxt, dst_nxt;
  logic [BYTE_W-1:0] rd_nxt;

  // Index 1 is the most significant writable lane
  for (genvar i = 0; i < NLANES; i++) begin : g_dec
    assign lane_wr[i] = cpu_we && (int'(cpu_addr) == NLANES - i);
  end
  assign io_wr = cpu_we && (int'(cpu_addr) == IDX_IO);

  dma_mem_ptr #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .wr_lane   (lane_wr),
    .wr_data   (cpu_wdata),
    .step_en   (xfer_done),
    .step_word (xfer_size),
    .step_mode (step_mode),
    .ptr_q     (ptr_q)
  );

  dma_io_reg #(.IO_W(IO_W)) u_io (
    .clk     (clk),
    .wr_en   (io_wr),
    .wr_data (cpu_wdata[IO_W-1:0]),
    .io_q    (io_q)
  );

  assign io_full = {{HI_W{1'b1}}, io_q};

  dma_addr_route #(.ADDR_W(ADDR_W)) u_route (
    .act_src  (act_src),
    .mem_addr (ptr_q),
    .io_addr  (io_full),
    .src_nxt  (src_nxt),
    .dst_nxt  (dst_nxt)
  );

  always_comb begin
    rd_nxt = '0;
    if (int'(cpu_addr) == IDX_RSV) begin
      rd_nxt = '1;
    end else if (int'(cpu_addr) == IDX_IO) begin
      rd_nxt = BYTE_W'(io_q);
    end else begin
      for (int i = 0; i < NLANES; i++) begin
        if (int'(cpu_addr) == NLANES - i) rd_nxt = ptr_q[i*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_addr  <= '0;
      dst_addr  <= '0;
      cpu_rdata <= '0;
    end else begin
      src_addr  <= src_nxt;
      dst_addr  <= dst_nxt;
      cpu_rdata <= rd_nxt;
    end
  end

  a_r1_reserved_ones: assert property (@(posedge clk) disable iff (rst)
    (int'(cpu_addr) == IDX_RSV) |=> cpu_rdata == '1);

  a_r3_mem_dest: assert property (@(posedge clk) disable iff (rst)
    (act_src == ACT_SER_RX || act_src == ACT_ADC_END) |=> dst_addr == $past(ptr_q));

  a_r4_mem_src: assert property (@(posedge clk) disable iff (rst)
    (act_src == ACT_OTHER_A || act_src == ACT_OTHER_B) |=> src_addr == $past(ptr_q));

  a_r5_io_upper: assert property (@(posedge clk) disable iff (rst)
    (act_src == ACT_SER_RX) |=> src_addr[ADDR_W-1:IO_W] == '1);

  a_r12_reset_clears: assert property (@(posedge clk)
    rst |=> (src_addr == '0 && dst_addr == '0 && cpu_rdata == '0));

endmodule

// File: tb/dma_addr_gen_tb.sv
module dma_addr_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  cpu_addr;
  logic        cpu_we;
  logic [7:0]  cpu_wdata;
  logic [7:0]  cpu_rdata;
  logic [1:0]  act_src;
  logic        xfer_size;
  logic [1:0]  step_mode;
  logic        xfer_done;
  logic [23:0] src_addr;
  logic [23:0] dst_addr;

  int checks = 0;
  int fails  = 0;

  dma_addr_gen u_dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .act_src(act_src),
    .xfer_size(xfer_size), .step_mode(step_mode), .xfer_done(xfer_done),
    .src_addr(src_addr), .dst_addr(dst_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_we = 1'b0;
    @(negedge clk);
    d = cpu_rdata;
  endtask

  task automatic set_mar(input logic [23:0] v);
    wr(3'd1, v[23:16]); wr(3'd2, v[15:8]); wr(3'd3, v[7:0]);
  endtask

  task automatic get_mar(output logic [23:0] v);
    logic [7:0] b;
    rd(3'd1, b); v[23:16] = b;
    rd(3'd2, b); v[15:8]  = b;
    rd(3'd3, b); v[7:0]   = b;
  endtask

  task automatic pulse(input logic sz, input logic [1:0] md);
    @(negedge clk);
    xfer_size = sz; step_mode = md; xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R12 src in reset", {8'h0, src_addr}, 32'h0);
    chk("R12 dst in reset", {8'h0, dst_addr}, 32'h0);
    chk("R12 rdata in reset", {24'h0, cpu_rdata}, 32'h0);
    rst = 1'b0;
  endtask

  task automatic t_bytes;
    logic [7:0] b; logic [23:0] v;
    set_mar(24'h123456);
    get_mar(v);
    chk("R2 pointer readback", {8'h0, v}, 32'h00123456);
    wr(3'd0, 8'h12);
    rd(3'd0, b);
    chk("R1 reserved reads ones", {24'h0, b}, 32'hFF);
    get_mar(v);
    chk("R1 reserved write no effect", {8'h0, v}, 32'h00123456);
    wr(3'd4, 8'h5A);
    rd(3'd4, b);
    chk("R5 io register readback", {24'h0, b}, 32'h5A);
  endtask

  task automatic t_route;
    act_src = 2'd0; repeat (2) @(negedge clk);
    chk("R4 act0 src", {8'h0, src_addr}, 32'h00123456);
    chk("R5 act0 dst io", {8'h0, dst_addr}, 32'h00FFFF5A);
    act_src = 2'd3; repeat (2) @(negedge clk);
    chk("R4 act3 src", {8'h0, src_addr}, 32'h00123456);
    act_src = 2'd1; repeat (2) @(negedge clk);
    chk("R3 serial dst", {8'h0, dst_addr}, 32'h00123456);
    chk("R3 serial src io", {8'h0, src_addr}, 32'h00FFFF5A);
    act_src = 2'd2; repeat (2) @(negedge clk);
    chk("R3 adc dst", {8'h0, dst_addr}, 32'h00123456);
    // R12 latency: change at negedge, not visible until next posedge
    act_src = 2'd0; #1;
    chk("R12 output held before edge", {8'h0, dst_addr}, 32'h00123456);
    @(negedge clk);
    chk("R12 output after one edge", {8'h0, src_addr}, 32'h00123456);
  endtask

  task automatic t_steps;
    logic [23:0] v;
    set_mar(24'h0000FE);
    pulse(1'b0, 2'd1); get_mar(v);
    chk("R6 inc byte", {8'h0, v}, 32'h000000FF);
    pulse(1'b1, 2'd1); get_mar(v);
    chk("R6 inc word carry", {8'h0, v}, 32'h00000101);
    pulse(1'b0, 2'd2); get_mar(v);
    chk("R7 dec byte", {8'h0, v}, 32'h00000100);
    pulse(1'b1, 2'd2); get_mar(v);
    chk("R7 dec word borrow", {8'h0, v}, 32'h000000FE);
    pulse(1'b1, 2'd0); get_mar(v);
    chk("R8 hold mode0", {8'h0, v}, 32'h000000FE);
    pulse(1'b0, 2'd3); get_mar(v);
    chk("R8 hold mode3", {8'h0, v}, 32'h000000FE);
    act_src = 2'd0; repeat (2) @(negedge clk);
    chk("R6 stepped pointer on src", {8'h0, src_addr}, 32'h000000FE);
  endtask

  task automatic t_wrap;
    logic [23:0] v; logic [7:0] b;
    set_mar(24'hFFFFFF);
    pulse(1'b1, 2'd1); get_mar(v);
    chk("R9 wrap up", {8'h0, v}, 32'h00000001);
    rd(3'd0, b);
    chk("R9 reserved after wrap", {24'h0, b}, 32'hFF);
    set_mar(24'h000000);
    pulse(1'b0, 2'd2); get_mar(v);
    chk("R9 wrap down", {8'h0, v}, 32'h00FFFFFF);
  endtask

  task automatic t_collide;
    logic [23:0] v;
    set_mar(24'h100010);
    @(negedge clk);
    cpu_addr = 3'd3; cpu_wdata = 8'h77; cpu_we = 1'b1;
    xfer_size = 1'b0; step_mode = 2'd1; xfer_done = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0; xfer_done = 1'b0;
    get_mar(v);
    chk("R10 write wins over step", {8'h0, v}, 32'h00100077);
  endtask

  task automatic t_reset_keep;
    logic [23:0] v; logic [7:0] b;
    set_mar(24'hABCDEF); wr(3'd4, 8'h3C);
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    get_mar(v);
    chk("R11 pointer kept over reset", {8'h0, v}, 32'h00ABCDEF);
    rd(3'd4, b);
    chk("R11 io kept over reset", {24'h0, b}, 32'h3C);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    rst = 1'b1; cpu_addr = '0; cpu_we = 1'b0; cpu_wdata = '0;
    act_src = '0; xfer_size = 1'b0; step_mode = '0; xfer_done = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_bytes();
    t_route();
    t_steps();
    t_wrap();
    t_collide();
    t_reset_keep();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule